// File: doc/BRIEF.md
# Bundle-Aligned Next Fetch Address Generator

This block holds the instruction fetch address of a front end that fetches fixed 16-byte instruction bundles, two bundles per cycle. Each cycle it picks the address for the next cycle. If nothing redirects it, the address steps forward by one fetch group. A taken branch sends it to a branch target. A resolution redirect overrides both. An external predictor or decoder stub supplies a branch descriptor for the fetch group shown at the output. The descriptor gives the branch kind, a taken flag, a signed displacement counted in bundles, a branch register index, and which of the two fetched bundles holds the branch.

There are four kinds of branch target. A short relative branch uses a 21-bit displacement. A long relative branch uses a 60-bit displacement that spans the whole address space. An indirect branch reads one of eight 64-bit branch registers. A counted-loop branch is predicted exactly from a loop count register. The branch registers and the loop count have their own write ports. All address arithmetic wraps modulo 2^64 and raises no fault.

Top module: `bundle_fetch_addr`

## Requirements
- R1: While reset is asserted, and for the first cycle after it is released, `fetch_pc_o` equals `RESET_VEC` and `fetch_vld_o` is 0. During that invalid cycle, redirect and branch inputs have no effect. From the next cycle on, `fetch_vld_o` stays 1.
- R2: Bits [3:0] of `fetch_pc_o` are always zero. A redirect address has its low 4 bits cleared before use.
- R3: With no redirect and no taken branch, the next address is the current address plus 32.
- R4: A short branch (kind 2'b00) has target = base + sign-extended `br_disp_i[20:0]` × 16. Base is `fetch_pc_o` when `br_hi_i` is 0, or `fetch_pc_o` + 16 when `br_hi_i` is 1.
- R5: A long branch (kind 2'b01) has target = base + sign-extended `br_disp_i[59:0]` × 16, with base as in R4.
- R6: An indirect branch (kind 2'b10) targets branch register `br_idx_i`, with its low 4 bits cleared. All eight registers reset to zero.
- R7: If a branch register write and an indirect branch that reads the same register fall in the same cycle, the target uses the value being written.
- R8: A counted-loop branch (kind 2'b11) ignores `br_taken_i`. It is taken to the R4 target exactly when the loop count is non-zero. Each consumed loop branch with a non-zero count decrements the count by one. At zero the branch falls through and the count stays zero.
- R9: A loop count write takes effect from the next cycle. If it falls in the same cycle as a loop branch, the branch sees the old count and the written value wins over the decrement.
- R10: Priority is redirect, then taken branch, then sequential. A loop branch that coincides with a redirect is not consumed and leaves the count unchanged.
- R11: A short, long or indirect branch with `br_taken_i` low advances sequentially.
- R12: Sequential and relative arithmetic wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Resolution redirect request |
| rd_addr_i | input | 64 | Redirect address |
| br_vld_i | input | 1 | Branch descriptor present |
| br_kind_i | input | 2 | 00 short, 01 long, 10 indirect, 11 counted loop |
| br_taken_i | input | 1 | Predicted taken (ignored for loop kind) |
| br_hi_i | input | 1 | Branch sits in second bundle of the group |
| br_disp_i | input | 60 | Signed displacement in bundles |
| br_idx_i | input | 3 | Branch register index for indirect |
| bw_en_i | input | 1 | Branch register write enable |
| bw_idx_i | input | 3 | Branch register write index |
| bw_data_i | input | 64 | Branch register write data |
| lc_we_i | input | 1 | Loop count write enable |
| lc_data_i | input | 64 | Loop count write data |
| fetch_pc_o | output | 64 | Current aligned fetch address |
| fetch_vld_o | output | 1 | Fetch address valid |

## Verification
The bench first runs plain sequential steps. It then runs short and long branches with positive and negative displacements from each of the two bundle positions, which separates the base selection from the sign extension and the scaling. Indirect branches are run with and without a same-cycle register write, which shows whether forwarding is present. A loop count is loaded and then run down to zero and past it, with a redirect inserted and a count write landing on a loop branch, to check exact loop prediction, decrement suppression and write priority. Redirects near the top of the address space, followed by sequential steps, check the wrap.

// File: rtl/fag_pkg.sv
package fag_pkg;
  typedef enum logic [1:0] {
    BK_SHORT = 2'b00,
    BK_LONG  = 2'b01,
    BK_IND   = 2'b10,
    BK_LOOP  = 2'b11
  } br_kind_e;

  localparam int BUNDLE_LSB   = 4;
  localparam int BUNDLE_BYTES = 1 << BUNDLE_LSB;
endpackage

// File: rtl/fag_breg_file.sv
module fag_breg_file #(
  parameter int NUM = 8,
  parameter int W   = 64,
  localparam int IW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0]   regs_q [NUM];
  logic [NUM-1:0] wen;

  for (genvar g = 0; g < NUM; g++) begin : g_dec
    assign wen[g] = we_i && (widx_i == IW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM; i++) begin
        if (wen[i]) regs_q[i] <= wdata_i;
      end
    end
  end

  // same-cycle write forwards to the reader
  always_comb begin
    if (we_i && (widx_i == ridx_i)) rdata_o = wdata_i;
    else                            rdata_o = regs_q[ridx_i];
  end
endmodule

// File: rtl/fag_loop_ctr.sv
module fag_loop_ctr #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         consume_i,
  output logic         nonzero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign nonzero_o = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (we_i)                        cnt_d = wdata_i;
    else if (consume_i && nonzero_o) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fag_target.sv
module fag_target
  import fag_pkg::*;
#(
  parameter int AW  = 64,
  parameter int SDW = 21,
  parameter int LDW = 60
) (
  input  logic [AW-1:0]  pc_i,
  input  logic           hi_i,
  input  br_kind_e       kind_i,
  input  logic [LDW-1:0] disp_i,
  input  logic [AW-1:0]  breg_i,
  output logic [AW-1:0]  tgt_o
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(BUNDLE_BYTES - 1);

  logic [AW-1:0] base, off_s, off_l;

  always_comb begin
    base  = pc_i + (hi_i ? AW'(BUNDLE_BYTES) : '0);
    off_s = {{(AW-SDW){disp_i[SDW-1]}}, disp_i[SDW-1:0]} << BUNDLE_LSB;
    off_l = {{(AW-LDW){disp_i[LDW-1]}}, disp_i} << BUNDLE_LSB;
    case (kind_i)
      BK_LONG: tgt_o = base + off_l;
      BK_IND:  tgt_o = breg_i & ALIGN_MASK;
      default: tgt_o = base + off_s;
    endcase
  end
endmodule

// File: rtl/bundle_fetch_addr.sv
module bundle_fetch_addr
  import fag_pkg::*;
#(
  parameter int              ADDR_W    = 64,
  parameter int              SDISP_W   = 21,
  parameter int              LDISP_W   = 60,
  parameter int              NUM_BREG  = 8,
  parameter int              LC_W      = 64,
  parameter int              FETCH_BUN = 2,
  parameter logic [ADDR_W-1:0] RESET_VEC = 64'h0000_0000_0010_0000,
  localparam int             BIW       = $clog2(NUM_BREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic               br_vld_i,
  input  logic [1:0]         br_kind_i,
  input  logic               br_taken_i,
  input  logic               br_hi_i,
  input  logic [LDISP_W-1:0] br_disp_i,
  input  logic [BIW-1:0]     br_idx_i,
  input  logic               bw_en_i,
  input  logic [BIW-1:0]     bw_idx_i,
  input  logic [ADDR_W-1:0]  bw_data_i,
  input  logic               lc_we_i,
  input  logic [LC_W-1:0]    lc_data_i,
  output logic [ADDR_W-1:0]  fetch_pc_o,
  output logic               fetch_vld_o
);
  localparam logic [ADDR_W-1:0] SEQ_STEP   = ADDR_W'(FETCH_BUN * BUNDLE_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BUNDLE_BYTES - 1);

  logic [ADDR_W-1:0] pc_q, pc_d, tgt, breg_val;
  logic              vld_q, vld_d;
  logic              lc_nz, is_loop, take, consume;
  br_kind_e          kind;

  assign kind    = br_kind_e'(br_kind_i);
  assign is_loop = (kind == BK_LOOP);
  assign consume = vld_q && br_vld_i && is_loop && !rd_en_i;

  fag_breg_file #(.NUM(NUM_BREG), .W(ADDR_W)) u_breg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (bw_en_i),
    .widx_i  (bw_idx_i),
    .wdata_i (bw_data_i),
    .ridx_i  (br_idx_i),
    .rdata_o (breg_val)
  );

  fag_loop_ctr #(.W(LC_W)) u_lc (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (lc_we_i),
    .wdata_i   (lc_data_i),
    .consume_i (consume),
    .nonzero_o (lc_nz)
  );

  fag_target #(.AW(ADDR_W), .SDW(SDISP_W), .LDW(LDISP_W)) u_tgt (
    .pc_i   (pc_q),
    .hi_i   (br_hi_i),
    .kind_i (kind),
    .disp_i (br_disp_i),
    .breg_i (breg_val),
    .tgt_o  (tgt)
  );

  always_comb begin
    take  = br_vld_i && (is_loop ? lc_nz : br_taken_i);
    vld_d = 1'b1;
    if (!vld_q)       pc_d = pc_q;
    else if (rd_en_i) pc_d = rd_addr_i & ALIGN_MASK;
    else if (take)    pc_d = tgt;
    else              pc_d = pc_q + SEQ_STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_VEC & ALIGN_MASK;
      vld_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      vld_q <= vld_d;
    end
  end

  assign fetch_pc_o  = pc_q;
  assign fetch_vld_o = vld_q;
endmodule

// File: rtl/bundle_fetch_addr_chk.sv
module bundle_fetch_addr_chk #(
  parameter int                ADDR_W    = 64,
  parameter logic [ADDR_W-1:0] RESET_VEC = 64'h0000_0000_0010_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              br_vld_i,
  input logic [ADDR_W-1:0] fetch_pc_o,
  input logic              fetch_vld_o
);
  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pc_o[3:0] == 4'h0);

  p_invalid_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld_o |-> fetch_pc_o == RESET_VEC);

  p_vld_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld_o |=> fetch_vld_o);

  p_invalid_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld_o |=> $stable(fetch_pc_o));

  p_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld_o && rd_en_i) |=>
      fetch_pc_o == ($past(rd_addr_i) & ~ADDR_W'(15)));

  p_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld_o && !rd_en_i && !br_vld_i) |=>
      fetch_pc_o == $past(fetch_pc_o) + ADDR_W'(32));
endmodule

bind bundle_fetch_addr bundle_fetch_addr_chk #(
  .ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
  .br_vld_i(br_vld_i), .fetch_pc_o(fetch_pc_o), .fetch_vld_o(fetch_vld_o)
);

// File: tb/bundle_fetch_addr_tb.sv
module bundle_fetch_addr_tb;
  localparam logic [63:0] RV = 64'h0000_0000_0010_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en;
  logic [63:0] rd_addr;
  logic        br_vld, br_taken, br_hi;
  logic [1:0]  br_kind;
  logic [59:0] br_disp;
  logic [2:0]  br_idx;
  logic        bw_en;
  logic [2:0]  bw_idx;
  logic [63:0] bw_data;
  logic        lc_we;
  logic [63:0] lc_data;
  logic [63:0] pc;
  logic        vld;

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] q_pc[$];
  string       q_tag[$];

  // bench-side model state
  logic [63:0] m_pc;
  logic [63:0] m_lc;
  logic [63:0] m_br [8];

  always #5 clk = ~clk;

  bundle_fetch_addr #(.RESET_VEC(RV)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .br_vld_i(br_vld), .br_kind_i(br_kind), .br_taken_i(br_taken),
    .br_hi_i(br_hi), .br_disp_i(br_disp), .br_idx_i(br_idx),
    .bw_en_i(bw_en), .bw_idx_i(bw_idx), .bw_data_i(bw_data),
    .lc_we_i(lc_we), .lc_data_i(lc_data),
    .fetch_pc_o(pc), .fetch_vld_o(vld)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [63:0] sx21(input logic [59:0] d);
    return {{43{d[20]}}, d[20:0]} << 4;
  endfunction

  function automatic logic [63:0] sx60(input logic [59:0] d);
    return {{4{d[59]}}, d} << 4;
  endfunction

  // driver: apply one cycle of stimulus and push the expected next address
  task automatic step(input logic rd, input logic [63:0] rda,
                      input logic bv, input logic [1:0] kd, input logic tk,
                      input logic hi, input logic [59:0] dp, input logic [2:0] ix,
                      input logic bw, input logic [2:0] bwi, input logic [63:0] bwd,
                      input logic lw, input logic [63:0] lwd, input string tag);
    logic [63:0] base, nxt, rv;
    logic        tak;
    @(negedge clk);
    rd_en = rd; rd_addr = rda; br_vld = bv; br_kind = kd; br_taken = tk;
    br_hi = hi; br_disp = dp; br_idx = ix; bw_en = bw; bw_idx = bwi;
    bw_data = bwd; lc_we = lw; lc_data = lwd;
    base = m_pc + (hi ? 64'd16 : 64'd0);
    rv   = (bw && bwi == ix) ? bwd : m_br[ix];
    tak  = bv && ((kd == 2'b11) ? (m_lc != 0) : tk);
    if (rd)       nxt = rda & ~64'hF;
    else if (tak) begin
      case (kd)
        2'b01:   nxt = base + sx60(dp);
        2'b10:   nxt = rv & ~64'hF;
        default: nxt = base + sx21(dp);
      endcase
    end else      nxt = m_pc + 64'd32;
    if (lw) m_lc = lwd;
    else if (bv && kd == 2'b11 && !rd && m_lc != 0) m_lc = m_lc - 1;
    if (bw) m_br[bwi] = bwd;
    m_pc = nxt;
    q_pc.push_back(nxt);
    q_tag.push_back(tag);
  endtask

  task automatic seq(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q_pc.size() > 0) check(pc, q_pc.pop_front(), q_tag.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; rd_en = 0; rd_addr = 0; br_vld = 0; br_kind = 0; br_taken = 0;
    br_hi = 0; br_disp = 0; br_idx = 0; bw_en = 0; bw_idx = 0; bw_data = 0;
    lc_we = 0; lc_data = 0;
    m_pc = RV; m_lc = 0;
    for (int i = 0; i < 8; i++) m_br[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check(pc, RV, "R1 pc in reset");
    check({63'd0, vld}, 64'd0, "R1 vld in reset");
    @(negedge clk);
    rst_n = 1;
    // R1: invalid cycle, a redirect here must be ignored
    rd_en = 1; rd_addr = 64'h5000;
    #1;
    check({63'd0, vld}, 64'd0, "R1 vld first cycle");
    @(posedge clk); #1;
    check({63'd0, vld}, 64'd1, "R1 vld rises");
    check(pc, RV, "R1 pc held during invalid cycle");
    rd_en = 0;

    seq("R3 sequential a");
    seq("R3 sequential b");
    // R4 short, positive, low bundle
    step(0, 0, 1, 2'b00, 1, 0, 60'd5, 0, 0, 0, 0, 0, 0, "R4 short fwd lo");
    // R4 short, negative, high bundle; upper disp bits must not matter
    step(0, 0, 1, 2'b00, 1, 1, {39'h7F_FFFF_FFFF, 21'h1F_FFFD}, 0, 0, 0, 0, 0, 0, "R4 short back hi");
    // R11 not taken falls through
    step(0, 0, 1, 2'b00, 0, 0, 60'd100, 0, 0, 0, 0, 0, 0, "R11 short not taken");
    // R5 long forward and backward
    step(0, 0, 1, 2'b01, 1, 1, 60'h0_0001_0000_0000, 0, 0, 0, 0, 0, 0, "R5 long fwd hi");
    step(0, 0, 1, 2'b01, 1, 0, 60'hFFF_FFFF_0000_0000, 0, 0, 0, 0, 0, 0, "R5 long back");
    step(0, 0, 1, 2'b01, 0, 0, 60'h123, 0, 0, 0, 0, 0, 0, "R11 long not taken");
    // R6 indirect: write reg 2, then branch through it (unaligned value)
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd2, 64'h0000_1234_5678_9ABF, 0, 0, "R6 breg write");
    step(0, 0, 1, 2'b10, 1, 0, 0, 3'd2, 0, 0, 0, 0, 0, "R6 indirect");
    step(0, 0, 1, 2'b10, 1, 0, 0, 3'd5, 0, 0, 0, 0, 0, "R6 indirect reset reg");
    // R7 forwarding
    step(0, 0, 1, 2'b10, 1, 0, 0, 3'd3, 1, 3'd3, 64'h0000_0000_00AB_CDE7, 0, 0, "R7 forward");
    step(0, 0, 1, 2'b10, 0, 0, 0, 3'd3, 0, 0, 0, 0, 0, "R11 indirect not taken");
    // R8 counted loop
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 64'd2, "R9 lc write");
    step(0, 0, 1, 2'b11, 0, 0, 60'h1F_FFFE, 0, 0, 0, 0, 0, 0, "R8 loop taken 2");
    step(1, 64'h9_0008, 1, 2'b11, 0, 0, 60'd3, 0, 0, 0, 0, 0, 0, "R10 redirect over loop");
    step(0, 0, 1, 2'b11, 0, 1, 60'd3, 0, 0, 0, 0, 0, 0, "R8 loop taken 1");
    step(0, 0, 1, 2'b11, 1, 0, 60'd3, 0, 0, 0, 0, 0, 0, "R8 loop fall through 0");
    step(0, 0, 1, 2'b11, 1, 0, 60'd3, 0, 0, 0, 0, 0, 0, "R8 loop stays 0");
    // R9 write during loop branch: old count (0) used, written value wins
    step(0, 0, 1, 2'b11, 0, 0, 60'd7, 0, 0, 0, 0, 1, 64'd1, "R9 write with loop");
    step(0, 0, 1, 2'b11, 0, 0, 60'd7, 0, 0, 0, 0, 0, 0, "R9 new count taken");
    step(0, 0, 1, 2'b11, 0, 0, 60'd7, 0, 0, 0, 0, 0, 0, "R9 count exhausted");
    // R10 redirect over a taken branch
    step(1, 64'h0000_0000_0077_0019, 1, 2'b00, 1, 0, 60'd9, 0, 0, 0, 0, 0, 0, "R10 redirect wins");
    // R12 wrap
    step(1, 64'hFFFF_FFFF_FFFF_FFE0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 redirect high");
    seq("R12 sequential wrap");
    step(1, 64'hFFFF_FFFF_FFFF_FFF0, 1, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 redirect top");
    step(0, 0, 1, 2'b00, 1, 1, 60'd2, 0, 0, 0, 0, 0, 0, "R12 short wrap");
    seq("R3 sequential end");

    @(negedge clk);
    br_vld = 0; rd_en = 0; bw_en = 0; lc_we = 0;
    repeat (3) @(posedge clk);
    #2;
    check(64'(q_pc.size()), 64'd0, "scoreboard drained");
    summary();
    $finish;
  end
endmodule